// File: doc/BRIEF.md
# ATA Device Task-File Register Interface

This block is the register file on the device side of a parallel ATA drive port. The host reaches it through two active-low chip selects, one for the command block and one for the control block, a 3-bit register address, and single-cycle read and write strobes sampled on the block clock. Reads are combinational while the read strobe is high. Each read returns an 8-bit value together with a per-bit output enable, so the pad ring can leave any bit it does not drive at high impedance.

Two drives can share one cable. Every register write is stored by both drives. Register reads and the interrupt line answer only in the drive whose jumper identity matches the drive-select bit of the device/head register. The block handles four pieces of control state: the pending-interrupt flag, the interrupt output enable, software reset, and a simple busy/complete handshake with the command engine. A write to the command register raises a one-cycle start pulse. A completion pulse from the engine ends the busy state and raises an interrupt. The 16-bit data port is handled by a separate transfer engine, so this block neither drives nor stores accesses to it.

Top module: `ata_taskfile_regs`

## Requirements
- R1: With only the command chip select asserted, the addresses map as follows: 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 device/head. Each of these reads back what was last stored. Address 1 reads `err_code` and writes the features register. Address 0 (data port) is never driven, and writes to it change nothing.
- R2: With only the control chip select asserted, address 6 reads alternate status and writes device control, and address 7 reads the drive-address byte. Addresses 0 to 5 drive nothing, and writes to them change nothing.
- R3: When both chip selects are asserted, or both are negated, a read drives no bit and a write is discarded.
- R4: The status byte is {BSY, `dev_stat[6:0]`}, with BSY in bit 7. Alternate status returns the same byte.
- R5: A status read (command block, address 7) by the selected drive clears the pending interrupt. An alternate status read leaves it unchanged.
- R6: `intrq_oe` is high only when device-control bit 1 (interrupt disable) is 0 and the device/head bit 4 equals `drive_id`. `intrq` carries the pending flag.
- R7: Reads drive data only when device/head bit 4 equals `drive_id`. Writes are stored whatever that bit holds.
- R8: Device/head bits 7 and 5 always read as 1. Bit 6 is the address-mode flag and bits 3..0 are the head. The drive-address byte returns bit 6 = NOT `wr_gate`, bits 5..2 = NOT head, bit 1 = 0 only when bit 4 is 1, and bit 0 = 0 only when bit 4 is 0. Bit 7 is never driven (enable mask 0x7F).
- R9: A command write is accepted when device/head bit 4 equals `drive_id`, or when the code is 0x90 (run diagnostics) and bit 4 is 0. An accepted command pulses `cmd_start` for the cycle after the write, presents the code on `cmd_code`, and sets BSY. A rejected command does neither.
- R10: A `cmd_done` pulse while BSY is set clears BSY and sets the pending interrupt.
- R11: While BSY is set, writes to command-block registers other than the command register are ignored.
- R12: Device-control bit 2 drives `soft_rst`. While it is set, BSY reads 1, the pending flag is cleared, commands are rejected, and the task file returns to its reset values.
- R13: After reset, sector count and sector number read 0x01, both cylinder bytes read 0x00, device/head reads 0xA0, BSY is 0 and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_cmd_n | input | 1 | Command-block chip select, active low |
| cs_ctl_n | input | 1 | Control-block chip select, active low |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| drive_id | input | 1 | Jumper identity: 0 or 1 |
| dev_stat | input | 7 | Status bits 6..0 from the drive |
| err_code | input | 8 | Error register contents |
| wr_gate | input | 1 | Media write in progress |
| cmd_done | input | 1 | Command completion pulse |
| rdata | output | 8 | Read data |
| rdata_oe | output | 8 | Per-bit read output enable |
| intrq | output | 1 | Interrupt level (pending flag) |
| intrq_oe | output | 1 | Interrupt line output enable |
| soft_rst | output | 1 | Software reset held by host |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_code | output | 8 | Last accepted command code |

## Verification
The bench targets these corner cases:
- An alternate status read between completion and a status read. A design that shared the acknowledge between the two reads would drop the interrupt early.
- Register writes made while the other drive is selected, later read back as this drive. A design that gated writes by selection would return stale bytes.
- A diagnostics command sent from both drives' point of view. A strict identity match would refuse it, and a loose one would also accept it when addressed to drive 1.
- Writes during BSY, and software reset while a command is written. A wrong design would corrupt the sector count or start a command in reset.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int REG_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int HEAD_W   = 4;
    localparam int STAT_W   = REG_W - 1;
    localparam int HEAD_LSB = 2;

    localparam logic [REG_W-1:0] DIAG_CODE = 8'h90;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_ERRFEAT,
        SEL_SECCNT,
        SEL_SECNUM,
        SEL_CYLLO,
        SEL_CYLHI,
        SEL_DEVHEAD,
        SEL_STATCMD,
        SEL_ALTCTL,
        SEL_DRVADDR
    } tf_sel_e;

    typedef struct packed {
        logic              one7;
        logic              lba;
        logic              one5;
        logic              drv;
        logic [HEAD_W-1:0] head;
    } devhead_t;

    typedef struct packed {
        logic srst;
        logic nien;
    } devctl_t;

    typedef struct packed {
        logic [REG_W-1:0] features;
        logic [REG_W-1:0] seccnt;
        logic [REG_W-1:0] secnum;
        logic [REG_W-1:0] cyllo;
        logic [REG_W-1:0] cylhi;
        devhead_t         devhead;
    } taskfile_t;

    localparam taskfile_t TF_DEFAULT = '{
        features: '0,
        seccnt:   8'h01,
        secnum:   8'h01,
        cyllo:    '0,
        cylhi:    '0,
        devhead:  '{one7: 1'b1, lba: 1'b0, one5: 1'b1, drv: 1'b0, head: '0}
    };

    function automatic tf_sel_e decode_sel(input logic cmd_n, input logic ctl_n,
                                           input logic [ADDR_W-1:0] a);
        tf_sel_e s;
        s = SEL_NONE;
        if (!cmd_n && ctl_n) begin
            case (a)
                3'd0:    s = SEL_DATA;
                3'd1:    s = SEL_ERRFEAT;
                3'd2:    s = SEL_SECCNT;
                3'd3:    s = SEL_SECNUM;
                3'd4:    s = SEL_CYLLO;
                3'd5:    s = SEL_CYLHI;
                3'd6:    s = SEL_DEVHEAD;
                default: s = SEL_STATCMD;
            endcase
        end else if (cmd_n && !ctl_n) begin
            if (a == 3'd6)      s = SEL_ALTCTL;
            else if (a == 3'd7) s = SEL_DRVADDR;
        end
        return s;
    endfunction

    function automatic devhead_t to_devhead(input logic [REG_W-1:0] w);
        devhead_t d;
        d      = devhead_t'(w);
        d.one7 = 1'b1;
        d.one5 = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic              cs_cmd_n,
    input  logic              cs_ctl_n,
    input  logic [ADDR_W-1:0] addr,
    output tf_sel_e           sel
);
    always_comb begin
        sel = decode_sel(cs_cmd_n, cs_ctl_n, addr);
        if (cs_cmd_n == cs_ctl_n) begin
            a_r3_invalid_cs_no_select: assert (sel == SEL_NONE);
        end
    end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter logic [REG_W-1:0] DIAG = DIAG_CODE
) (
    input  logic             clk,
    input  logic             rst,
    input  tf_sel_e          sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             drive_id,
    input  logic             cmd_done,
    output taskfile_t        tf,
    output devctl_t          devctl,
    output logic             bsy_q,
    output logic             pending,
    output logic             selected,
    output logic             cmd_start,
    output logic [REG_W-1:0] cmd_code
);
    logic cmd_accept;
    logic status_ack;

    assign selected   = (tf.devhead.drv == drive_id);
    assign cmd_accept = selected || ((wdata == DIAG) && !tf.devhead.drv);
    assign status_ack = rd_en && (sel == SEL_STATCMD) && selected;

    always_ff @(posedge clk) begin
        cmd_start <= 1'b0;
        if (rst) begin
            tf       <= TF_DEFAULT;
            devctl   <= '0;
            bsy_q    <= 1'b0;
            pending  <= 1'b0;
            cmd_code <= '0;
        end else begin
            if (wr_en && sel == SEL_ALTCTL) begin
                devctl <= '{srst: wdata[2], nien: wdata[1]};
            end
            if (devctl.srst) begin
                tf      <= TF_DEFAULT;
                bsy_q   <= 1'b0;
                pending <= 1'b0;
            end else begin
                if (status_ack) pending <= 1'b0;
                if (bsy_q && cmd_done) begin
                    bsy_q   <= 1'b0;
                    pending <= 1'b1;
                end
                if (wr_en) begin
                    case (sel)
                        SEL_STATCMD: if (cmd_accept) begin
                            bsy_q     <= 1'b1;
                            cmd_start <= 1'b1;
                            cmd_code  <= wdata;
                        end
                        SEL_ERRFEAT: if (!bsy_q) tf.features <= wdata;
                        SEL_SECCNT:  if (!bsy_q) tf.seccnt   <= wdata;
                        SEL_SECNUM:  if (!bsy_q) tf.secnum   <= wdata;
                        SEL_CYLLO:   if (!bsy_q) tf.cyllo    <= wdata;
                        SEL_CYLHI:   if (!bsy_q) tf.cylhi    <= wdata;
                        SEL_DEVHEAD: if (!bsy_q) tf.devhead  <= to_devhead(wdata);
                        default: ;
                    endcase
                end
            end
        end
    end

    // R5: status acknowledge clears the pending flag
    a_r5_status_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_ack && !cmd_done) |=> !pending);

    // R5: alternate status read leaves the pending flag alone
    a_r5_alt_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && sel == SEL_ALTCTL && !cmd_done && !devctl.srst)
        |=> (pending == $past(pending)));

    // R10: completion while busy raises the interrupt
    a_r10_done_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (bsy_q && cmd_done && !devctl.srst) |=> (pending && !bsy_q));

    // R11: sector count is frozen while busy
    a_r11_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (bsy_q && wr_en && sel == SEL_SECCNT && !devctl.srst) |=> $stable(tf.seccnt));

    // R9: a start pulse always comes with BSY
    a_r9_start_implies_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> bsy_q);

    // R12: software reset empties the busy and pending state
    a_r12_srst_clears: assert property (@(posedge clk) disable iff (rst)
        devctl.srst |=> (!pending && !cmd_start));
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
(
    input  logic             rst,
    input  tf_sel_e          sel,
    input  logic             rd_en,
    input  logic             selected,
    input  taskfile_t        tf,
    input  logic             bsy,
    input  logic [STAT_W-1:0] dev_stat,
    input  logic [REG_W-1:0] err_code,
    input  logic             wr_gate,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] rdata_oe
);
    localparam logic [REG_W-1:0] OE_ALL     = '1;
    localparam logic [REG_W-1:0] OE_DRVADDR = {1'b0, {(REG_W-1){1'b1}}};

    logic [REG_W-1:0] status_b;
    logic [REG_W-1:0] drvaddr_b;

    assign status_b = {bsy, dev_stat};

    assign drvaddr_b[REG_W-1] = 1'b0;
    assign drvaddr_b[REG_W-2] = ~wr_gate;
    assign drvaddr_b[1]       = ~tf.devhead.drv;
    assign drvaddr_b[0]       = tf.devhead.drv;
    for (genvar i = 0; i < HEAD_W; i++) begin : g_nhead
        assign drvaddr_b[HEAD_LSB+i] = ~tf.devhead.head[i];
    end

    always_comb begin
        rdata    = '0;
        rdata_oe = '0;
        if (rd_en && selected) begin
            rdata_oe = OE_ALL;
            case (sel)
                SEL_ERRFEAT: rdata = err_code;
                SEL_SECCNT:  rdata = tf.seccnt;
                SEL_SECNUM:  rdata = tf.secnum;
                SEL_CYLLO:   rdata = tf.cyllo;
                SEL_CYLHI:   rdata = tf.cylhi;
                SEL_DEVHEAD: rdata = tf.devhead;
                SEL_STATCMD,
                SEL_ALTCTL:  rdata = status_b;
                SEL_DRVADDR: begin
                    rdata    = drvaddr_b;
                    rdata_oe = OE_DRVADDR;
                end
                default:     rdata_oe = '0;
            endcase
        end
        if (!rst && rdata_oe != '0) begin
            a_r7_read_needs_select: assert (rd_en && selected);
        end
        if (!rst && sel == SEL_DRVADDR) begin
            a_r8_drvaddr_bit7_float: assert (!rdata_oe[REG_W-1]);
        end
    end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter logic [7:0] DIAG = DIAG_CODE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_cmd_n,
    input  logic       cs_ctl_n,
    input  logic [2:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       drive_id,
    input  logic [6:0] dev_stat,
    input  logic [7:0] err_code,
    input  logic       wr_gate,
    input  logic       cmd_done,
    output logic [7:0] rdata,
    output logic [7:0] rdata_oe,
    output logic       intrq,
    output logic       intrq_oe,
    output logic       soft_rst,
    output logic       cmd_start,
    output logic [7:0] cmd_code
);
    tf_sel_e   sel;
    taskfile_t tf;
    devctl_t   devctl;
    logic      bsy_q;
    logic      pending;
    logic      selected;
    logic      bsy;

    ata_tf_decode u_decode (
        .cs_cmd_n (cs_cmd_n),
        .cs_ctl_n (cs_ctl_n),
        .addr     (addr),
        .sel      (sel)
    );

    ata_tf_regs #(.DIAG(DIAG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .drive_id  (drive_id),
        .cmd_done  (cmd_done),
        .tf        (tf),
        .devctl    (devctl),
        .bsy_q     (bsy_q),
        .pending   (pending),
        .selected  (selected),
        .cmd_start (cmd_start),
        .cmd_code  (cmd_code)
    );

    assign bsy = bsy_q | devctl.srst;

    ata_tf_rdmux u_rdmux (
        .rst      (rst),
        .sel      (sel),
        .rd_en    (rd_en),
        .selected (selected),
        .tf       (tf),
        .bsy      (bsy),
        .dev_stat (dev_stat),
        .err_code (err_code),
        .wr_gate  (wr_gate),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    assign intrq    = pending;
    assign intrq_oe = selected & ~devctl.nien;
    assign soft_rst = devctl.srst;

    // R6: the line is never enabled while interrupts are disabled
    a_r6_intrq_masked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ALTCTL && wdata[1]) |=> !intrq_oe);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_cmd_n = 1'b1, cs_ctl_n = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       drive_id = 1'b0;
    logic [6:0] dev_stat = 7'h50;
    logic [7:0] err_code = 8'hA5;
    logic       wr_gate = 1'b0;
    logic       cmd_done = 1'b0;
    logic [7:0] rdata, rdata_oe, cmd_code;
    logic       intrq, intrq_oe, soft_rst, cmd_start;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic [7:0] oe;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_regs u_dut (
        .clk(clk), .rst(rst), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .drive_id(drive_id), .dev_stat(dev_stat), .err_code(err_code),
        .wr_gate(wr_gate), .cmd_done(cmd_done), .rdata(rdata),
        .rdata_oe(rdata_oe), .intrq(intrq), .intrq_oe(intrq_oe),
        .soft_rst(soft_rst), .cmd_start(cmd_start), .cmd_code(cmd_code)
    );

    // monitor: compares every read against the scoreboard
    always @(negedge clk) begin
        if (rd_en && !finished) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: rdata=%h oe=%h", rdata, rdata_oe);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rdata_oe !== e.oe || ((rdata ^ e.d) & e.oe) !== 8'h00) begin
                    n_bad++;
                    $display("FAIL %s: actual data=%h oe=%h expected data=%h oe=%h",
                             e.tag, rdata, rdata_oe, e.d, e.oe);
                end
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic cn, input logic kn, input logic [2:0] a,
                          input logic [7:0] d);
        @(posedge clk); #1;
        cs_cmd_n = cn; cs_ctl_n = kn; addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
    endtask

    task automatic bus_rd(input logic cn, input logic kn, input logic [2:0] a,
                          input logic [7:0] d, input logic [7:0] oe, input string tag);
        exp_t e;
        e.d = d; e.oe = oe; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        cs_cmd_n = cn; cs_ctl_n = kn; addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
    endtask

    task automatic cw(input logic [2:0] a, input logic [7:0] d); bus_wr(1'b0, 1'b1, a, d); endtask
    task automatic kw(input logic [2:0] a, input logic [7:0] d); bus_wr(1'b1, 1'b0, a, d); endtask
    task automatic cr(input logic [2:0] a, input logic [7:0] d, input string t);
        bus_rd(1'b0, 1'b1, a, d, 8'hFF, t);
    endtask

    task automatic pulse_done();
        @(posedge clk); #1; cmd_done = 1'b1;
        @(posedge clk); #1; cmd_done = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R13 reset values
        cr(3'd2, 8'h01, "R13 seccnt reset");
        cr(3'd3, 8'h01, "R13 secnum reset");
        cr(3'd4, 8'h00, "R13 cyllo reset");
        cr(3'd5, 8'h00, "R13 cylhi reset");
        cr(3'd6, 8'hA0, "R13 devhead reset");
        cr(3'd7, 8'h50, "R4 status idle");
        chk({7'd0, intrq}, 8'd0, "R13 no pending after reset");
        chk({7'd0, intrq_oe}, 8'd1, "R6 intrq enabled when selected");

        // R1 / R8 register map
        cw(3'd2, 8'h12); cw(3'd3, 8'h34); cw(3'd4, 8'h56); cw(3'd5, 8'h78);
        cw(3'd6, 8'h4B); cw(3'd1, 8'h5A); cw(3'd0, 8'hEE);
        cr(3'd2, 8'h12, "R1 seccnt");
        cr(3'd3, 8'h34, "R1 secnum");
        cr(3'd4, 8'h56, "R1 cyllo");
        cr(3'd5, 8'h78, "R1 cylhi");
        cr(3'd6, 8'hEB, "R8 devhead fixed ones");
        cr(3'd1, 8'hA5, "R1 error register");
        bus_rd(1'b0, 1'b1, 3'd0, 8'h00, 8'h00, "R1 data port not driven");

        // R2 control block
        kw(3'd0, 8'h0E); kw(3'd5, 8'h0E);
        chk({7'd0, soft_rst}, 8'd0, "R2 ignored ctl write srst");
        chk({7'd0, intrq_oe}, 8'd1, "R2 ignored ctl write nien");
        for (int i = 0; i < 6; i++) bus_rd(1'b1, 1'b0, 3'(i), 8'h00, 8'h00, "R2 ctl hole");
        bus_rd(1'b1, 1'b0, 3'd6, 8'h50, 8'hFF, "R4 alt status");
        bus_rd(1'b1, 1'b0, 3'd7, 8'h52, 8'h7F, "R8 drive address");
        wr_gate = 1'b1;
        bus_rd(1'b1, 1'b0, 3'd7, 8'h12, 8'h7F, "R8 drive address write gate");
        wr_gate = 1'b0;

        // R3 invalid selects
        bus_wr(1'b0, 1'b0, 3'd2, 8'h99);
        bus_wr(1'b1, 1'b1, 3'd2, 8'h98);
        cr(3'd2, 8'h12, "R3 invalid writes discarded");
        bus_rd(1'b0, 1'b0, 3'd2, 8'h00, 8'h00, "R3 both asserted read");
        bus_rd(1'b1, 1'b1, 3'd7, 8'h00, 8'h00, "R3 both negated read");

        // R9 / R11 / R10 / R5 command cycle
        cw(3'd7, 8'h20);
        chk({7'd0, cmd_start}, 8'd1, "R9 start pulse");
        chk(cmd_code, 8'h20, "R9 command code");
        @(posedge clk); #1;
        chk({7'd0, cmd_start}, 8'd0, "R9 start is one cycle");
        cr(3'd7, 8'hD0, "R4 status busy");
        cw(3'd2, 8'h77);
        cr(3'd2, 8'h12, "R11 write ignored while busy");
        pulse_done();
        chk({7'd0, intrq}, 8'd1, "R10 pending after done");
        bus_rd(1'b1, 1'b0, 3'd6, 8'h50, 8'hFF, "R10 busy cleared");
        chk({7'd0, intrq}, 8'd1, "R5 alt read keeps pending");
        cr(3'd7, 8'h50, "R5 status read");
        chk({7'd0, intrq}, 8'd0, "R5 status read clears pending");

        // R6 interrupt enable
        kw(3'd6, 8'h0A);
        chk({7'd0, intrq_oe}, 8'd0, "R6 disabled by nien");
        kw(3'd6, 8'h08);
        chk({7'd0, intrq_oe}, 8'd1, "R6 re-enabled");

        // R7 / R9 other drive selected
        cw(3'd6, 8'h10);
        chk({7'd0, intrq_oe}, 8'd0, "R6 off when not selected");
        bus_rd(1'b0, 1'b1, 3'd7, 8'h00, 8'h00, "R7 read gated");
        cw(3'd2, 8'h44);
        cw(3'd7, 8'h20);
        chk({7'd0, cmd_start}, 8'd0, "R9 reject other drive command");
        cw(3'd7, 8'h90);
        chk({7'd0, cmd_start}, 8'd0, "R9 reject diag to drive 1");
        cw(3'd6, 8'h00);
        cr(3'd2, 8'h44, "R7 write stored while deselected");
        cr(3'd7, 8'h50, "R9 no busy after rejects");

        // R9 diagnostics seen by drive 1
        drive_id = 1'b1;
        cw(3'd7, 8'h90);
        chk({7'd0, cmd_start}, 8'd1, "R9 diag accepted by drive 1");
        pulse_done();
        chk({7'd0, intrq_oe}, 8'd0, "R6 deselected line off");
        drive_id = 1'b0;
        #1;
        chk({7'd0, intrq}, 8'd1, "R10 pending from diag");
        cr(3'd7, 8'h50, "R5 status ack diag");
        chk({7'd0, intrq}, 8'd0, "R5 cleared after diag");

        // R12 software reset
        cw(3'd2, 8'h66); cw(3'd6, 8'h4B);
        kw(3'd6, 8'h0C);
        chk({7'd0, soft_rst}, 8'd1, "R12 soft_rst high");
        cr(3'd7, 8'hD0, "R12 busy during reset");
        cw(3'd7, 8'h20);
        chk({7'd0, cmd_start}, 8'd0, "R12 command rejected in reset");
        kw(3'd6, 8'h08);
        chk({7'd0, soft_rst}, 8'd0, "R12 soft_rst released");
        cr(3'd2, 8'h01, "R12 seccnt defaulted");
        cr(3'd6, 8'hA0, "R12 devhead defaulted");
        cr(3'd7, 8'h50, "R12 idle after release");

        repeat (2) @(posedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule